// File: doc/BRIEF.md
# Dynamic Phase-Shift Step Sequencer

This block controls the variable phase-shift port of an on-chip clock manager. A client asks for a signed number of phase steps. The block turns that request into a series of single-step handshakes toward the clock manager. For each step it raises the enable strobe for exactly one cycle, with the direction line valid in that cycle. It then waits for the manager's one-cycle completion pulse, idles for one gap cycle, and only then issues the next step. Every signal runs on the phase-shift clock. The reset input is assumed to be already released synchronously to that clock.

The block keeps a signed running phase offset that moves by one for each completed step. A request whose final offset would fall outside a programmable symmetric window is refused as a whole, and no step is issued for it. A zero-step request finishes at once. The time to completion is unbounded, so a watchdog abandons a step that never completes, raises a timeout pulse and drops the rest of the request.

Top module: `phase_step_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ps_en` is low, `offset` is 0, `req_ready` is high, `busy` is low, and `done`, `err_range` and `err_timeout` are low.
- R2: `ps_incdec` is 1 (increment) for every strobe of a request with a positive step count and 0 (decrement) for every strobe of a negative one. It is valid in each cycle in which `ps_en` is high.
- R3: `ps_en` goes high in the cycle after a request is accepted and stays high for exactly one cycle. Each further strobe of the same request goes high two cycles after the cycle in which `ps_done` was seen high, which leaves one gap cycle between them.
- R4: Each `ps_done` seen while a step is pending changes `offset` by +1 (increment) or −1 (decrement), visible in the next cycle.
- R5: An accepted request of N ≠ 0 steps produces exactly |N| strobes. `done` pulses for one cycle in the cycle after the gap that follows the last completion, with `req_ready` high again in that same cycle.
- R6: A request with offset+N > limit or offset+N < −limit gives a one-cycle `err_range` pulse in the cycle after acceptance. It issues no strobe and leaves `offset` unchanged. Targets equal to ±limit are accepted.
- R7: A zero-step request gives a one-cycle `done` pulse in the cycle after acceptance, issues no strobe and keeps `req_ready` high.
- R8: `req_ready` is low and `busy` is high from the cycle after acceptance until the request ends. Requests presented meanwhile are ignored.
- R9: If `ps_done` is not seen within TIMEOUT_CYC cycles of waiting, a one-cycle `err_timeout` pulse follows. The block returns to ready, the remaining steps are dropped, and `offset` keeps the steps already completed.
- R10: A `ps_done` pulse while no step is pending does not change `offset` or any other output.
- R11: Asserting reset during a request immediately forces `ps_en` and `busy` low and `offset` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-shift clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| req_valid | input | 1 | Step request present |
| req_steps | input | STEP_W | Signed number of steps requested |
| req_ready | output | 1 | Block can accept a request this cycle |
| limit | input | OFS_W-1 | Magnitude of the allowed offset window |
| busy | output | 1 | A request is being executed |
| offset | output | OFS_W | Signed running phase offset in steps |
| done | output | 1 | One-cycle pulse: request finished |
| err_range | output | 1 | One-cycle pulse: request refused, target out of window |
| err_timeout | output | 1 | One-cycle pulse: a step never completed |
| ps_en | output | 1 | Phase-shift enable strobe to the clock manager |
| ps_incdec | output | 1 | Step direction, 1 = increment |
| ps_done | input | 1 | Completion pulse from the clock manager |

## Verification
The bench varies the completion latency from zero upward. This catches a sequencer that strobes on a fixed schedule, or that skips the gap cycle and issues the next strobe one cycle early. Requests that land exactly on ±limit and one step beyond it expose an off-by-one in the window check: either a legal request is refused, or an illegal one moves the offset. Stray completion pulses while idle, a request presented while busy, and a manager that stops answering mid-request catch designs that count unsolicited completions, accept overlapping work, or hang or lose the offset of completed steps after a timeout.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_GAP   = 2'd3
  } pss_state_e;
endpackage

// File: rtl/pss_offset.sv
// Running phase offset and window check of a prospective request.
module pss_offset #(
  parameter int STEP_W = 10,
  parameter int OFS_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_apply,
  input  logic              step_up,
  input  logic [STEP_W-1:0] req_steps,
  input  logic [OFS_W-2:0]  limit,
  output logic [OFS_W-1:0]  offset,
  output logic              range_ok
);
  localparam int SUM_W = ((STEP_W > OFS_W) ? STEP_W : OFS_W) + 2;

  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic signed [SUM_W-1:0] ofs_x, stp_x, target, lim_pos, lim_neg;

  always_comb begin
    ofs_x   = $signed({{(SUM_W-OFS_W){ofs_q[OFS_W-1]}}, ofs_q});
    stp_x   = $signed({{(SUM_W-STEP_W){req_steps[STEP_W-1]}}, req_steps});
    target  = ofs_x + stp_x;
    lim_pos = $signed({{(SUM_W-OFS_W+1){1'b0}}, limit});
    lim_neg = -lim_pos;
    range_ok = (target <= lim_pos) && (target >= lim_neg);
  end

  always_comb begin
    ofs_d = step_up ? (ofs_q + OFS_W'(1)) : (ofs_q - OFS_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
    end else if (step_apply) begin
      ofs_q <= ofs_d;
    end
  end

  assign offset = ofs_q;

  AST_OFS_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_q != $past(ofs_q)) |-> (((ofs_q - $past(ofs_q)) == OFS_W'(1)) || (($past(ofs_q) - ofs_q) == OFS_W'(1)))); // R4
  AST_OFS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_apply |=> $stable(ofs_q)); // R10
endmodule

// File: rtl/pss_watchdog.sv
// Counts cycles spent waiting for a completion pulse.
module pss_watchdog #(
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_clear,
  input  logic wd_run,
  output logic wd_expired
);
  localparam int CNT_W = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = wd_clear || (wd_run && (cnt_q != LAST));
    cnt_d  = wd_clear ? '0 : (cnt_q + CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign wd_expired = wd_run && (cnt_q == LAST);

  AST_WD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R9
  AST_WD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wd_clear |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/pss_ctrl.sv
// Step sequencer: accepts requests, strobes one step at a time, waits for completion.
module pss_ctrl
  import pss_pkg::*;
#(
  parameter int STEP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [STEP_W-1:0] req_steps,
  input  logic              range_ok,
  input  logic              ps_done,
  input  logic              wd_expired,
  output logic              wd_clear,
  output logic              wd_run,
  output logic              step_apply,
  output logic              step_up,
  output logic              ps_en,
  output logic              ps_incdec,
  output logic              busy,
  output logic              req_ready,
  output logic              done,
  output logic              err_range,
  output logic              err_timeout
);
  pss_state_e        state_q, state_d;
  logic [STEP_W-1:0] rem_q, rem_d, mag;
  logic              dir_q, dir_d;
  logic              done_q, done_d, erng_q, erng_d, etmo_q, etmo_d;
  logic              accept;

  always_comb begin
    accept = req_valid && (state_q == ST_IDLE);
    mag    = req_steps[STEP_W-1] ? (~req_steps + STEP_W'(1)) : req_steps;
  end

  always_comb begin
    state_d    = state_q;
    rem_d      = rem_q;
    dir_d      = dir_q;
    done_d     = 1'b0;
    erng_d     = 1'b0;
    etmo_d     = 1'b0;
    step_apply = 1'b0;
    wd_clear   = 1'b0;
    wd_run     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (!range_ok) begin
            erng_d = 1'b1;
          end else if (mag == '0) begin
            done_d = 1'b1;
          end else begin
            state_d = ST_ISSUE;
            rem_d   = mag;
            dir_d   = ~req_steps[STEP_W-1];
          end
        end
      end
      ST_ISSUE: begin
        wd_clear = 1'b1;
        state_d  = ST_WAIT;
      end
      ST_WAIT: begin
        wd_run = 1'b1;
        if (ps_done) begin
          step_apply = 1'b1;
          rem_d      = rem_q - STEP_W'(1);
          state_d    = ST_GAP;
        end else if (wd_expired) begin
          etmo_d  = 1'b1;
          rem_d   = '0;
          state_d = ST_IDLE;
        end
      end
      ST_GAP: begin
        if (rem_q == '0) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          state_d = ST_ISSUE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
      erng_q  <= 1'b0;
      etmo_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      dir_q   <= dir_d;
      done_q  <= done_d;
      erng_q  <= erng_d;
      etmo_q  <= etmo_d;
    end
  end

  assign step_up     = dir_q;
  assign ps_en       = (state_q == ST_ISSUE);
  assign ps_incdec   = dir_q;
  assign busy        = (state_q != ST_IDLE);
  assign req_ready   = (state_q == ST_IDLE);
  assign done        = done_q;
  assign err_range   = erng_q;
  assign err_timeout = etmo_q;

  AST_EN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ps_en |=> !ps_en); // R3
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !range_ok) |=> (!ps_en && !busy && err_range)); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ps_en && req_ready)); // R5
  AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> (req_ready && (rem_q == '0))); // R9
  AST_PENDING_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_q != '0) |-> busy); // R8
  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({done, err_range, err_timeout}) <= 1); // R5
endmodule

// File: rtl/phase_step_seq.sv
module phase_step_seq #(
  parameter int STEP_W      = 10,
  parameter int OFS_W       = 10,
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic signed [STEP_W-1:0] req_steps,
  output logic                     req_ready,
  input  logic [OFS_W-2:0]         limit,
  output logic                     busy,
  output logic signed [OFS_W-1:0]  offset,
  output logic                     done,
  output logic                     err_range,
  output logic                     err_timeout,
  output logic                     ps_en,
  output logic                     ps_incdec,
  input  logic                     ps_done
);
  logic             range_ok, step_apply, step_up;
  logic             wd_clear, wd_run, wd_expired;
  logic [OFS_W-1:0] ofs_raw;

  pss_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_steps(req_steps),
    .range_ok(range_ok), .ps_done(ps_done), .wd_expired(wd_expired),
    .wd_clear(wd_clear), .wd_run(wd_run),
    .step_apply(step_apply), .step_up(step_up),
    .ps_en(ps_en), .ps_incdec(ps_incdec),
    .busy(busy), .req_ready(req_ready),
    .done(done), .err_range(err_range), .err_timeout(err_timeout)
  );

  pss_offset #(.STEP_W(STEP_W), .OFS_W(OFS_W)) u_offset (
    .clk(clk), .rst_n(rst_n),
    .step_apply(step_apply), .step_up(step_up),
    .req_steps(req_steps), .limit(limit),
    .offset(ofs_raw), .range_ok(range_ok)
  );

  pss_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wd (
    .clk(clk), .rst_n(rst_n),
    .wd_clear(wd_clear), .wd_run(wd_run), .wd_expired(wd_expired)
  );

  assign offset = ofs_raw;
endmodule

// File: tb/phase_step_seq_test.sv
`timescale 1ns/1ps
module phase_step_seq_test;
  localparam int TMO = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic signed [9:0] req_steps = '0;
  logic [8:0] limit = 9'd20;
  logic ps_done = 1'b0;
  logic req_ready, busy, done, err_range, err_timeout, ps_en, ps_incdec;
  logic signed [9:0] offset;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  phase_step_seq #(.STEP_W(10), .OFS_W(10), .TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_steps(req_steps),
    .req_ready(req_ready), .limit(limit), .busy(busy), .offset(offset),
    .done(done), .err_range(err_range), .err_timeout(err_timeout),
    .ps_en(ps_en), .ps_incdec(ps_incdec), .ps_done(ps_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 strobe, 2 waiting, 3 gap
  int m_ph, m_rem, m_ofs, m_wd;
  bit m_up, m_done, m_erng, m_etmo;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_rem = 0; m_ofs = 0; m_wd = 0; m_up = 0;
      m_done = 0; m_erng = 0; m_etmo = 0;
    end else begin
      m_done = 0; m_erng = 0; m_etmo = 0;
      case (m_ph)
        0: if (req_valid) begin
             int s, t;
             s = req_steps;
             t = m_ofs + s;
             if (t > int'(limit) || t < -int'(limit)) m_erng = 1;
             else if (s == 0) m_done = 1;
             else begin m_ph = 1; m_rem = (s < 0) ? -s : s; m_up = (s > 0); end
           end
        1: begin m_ph = 2; m_wd = 0; end
        2: if (ps_done) begin
             m_ofs = m_ofs + (m_up ? 1 : -1);
             m_rem = m_rem - 1; m_ph = 3;
           end else if (m_wd == TMO - 1) begin
             m_etmo = 1; m_rem = 0; m_ph = 0;
           end else m_wd = m_wd + 1;
        default: if (m_rem == 0) begin m_ph = 0; m_done = 1; end else m_ph = 1;
      endcase
    end
  end

  // Per-cycle comparison and event counters
  int en_cnt = 0, done_cnt = 0, rng_cnt = 0, tmo_cnt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(ps_en == (m_ph == 1), "R3 ps_en strobe timing", ps_en, m_ph == 1);
      if (ps_en) chk(ps_incdec == m_up, "R2 ps_incdec direction", ps_incdec, m_up);
      chk(req_ready == (m_ph == 0), "R8 req_ready", req_ready, m_ph == 0);
      chk(busy == (m_ph != 0), "R8 busy", busy, m_ph != 0);
      chk(int'(offset) == m_ofs, "R4 offset", offset, m_ofs);
      chk(done == m_done, "R5 done pulse", done, m_done);
      chk(err_range == m_erng, "R6 err_range pulse", err_range, m_erng);
      chk(err_timeout == m_etmo, "R9 err_timeout pulse", err_timeout, m_etmo);
      if (ps_en) en_cnt++;
      if (done) done_cnt++;
      if (err_range) rng_cnt++;
      if (err_timeout) tmo_cnt++;
    end
  end

  // Clock-manager responder with varying latency
  int rsp_cnt = -1, rsp_lat = 0;
  bit rsp_on = 1, stray = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      rsp_cnt = -1; ps_done = 0;
    end else begin
      ps_done = 0;
      if (stray) begin ps_done = 1; stray = 0; end
      if (rsp_cnt == 0) begin ps_done = 1; rsp_cnt = -1; end
      else if (rsp_cnt > 0) rsp_cnt--;
      if (ps_en && rsp_on) begin
        rsp_cnt = rsp_lat;
        rsp_lat = (rsp_lat * 5 + 3) % 7;
      end
    end
  end

  task automatic wait_idle;
    do @(negedge clk); while (!req_ready);
  endtask

  task automatic send(input int s);
    wait_idle();
    #1; req_valid = 1; req_steps = 10'(s);
    @(negedge clk); #1; req_valid = 0;
  endtask

  task automatic settle;
    wait_idle();
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int d0, r0, t0;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!ps_en && !busy && req_ready, "R1 outputs in reset", {ps_en, busy, req_ready}, 1);
    chk(offset == 0, "R1 offset in reset", offset, 0);
    #1 rst_n = 1;
    @(negedge clk); #1;
    chk(!ps_en && req_ready && !done && !err_range && !err_timeout, "R1 first cycle", ps_en, 0);
    chk(offset == 0, "R1 offset after reset", offset, 0);

    // R5, R4 positive request
    en_cnt = 0; d0 = done_cnt;
    send(3); settle();
    chk(en_cnt == 3, "R5 strobe count +3", en_cnt, 3);
    chk(offset == 3, "R4 offset after +3", offset, 3);
    chk(done_cnt == d0 + 1, "R5 one done", done_cnt, d0 + 1);

    // R2 negative request
    en_cnt = 0;
    send(-5); settle();
    chk(en_cnt == 5, "R5 strobe count -5", en_cnt, 5);
    chk(offset == -2, "R2 offset after -5", offset, -2);

    // R7 zero steps
    en_cnt = 0; d0 = done_cnt;
    send(0); settle();
    chk(en_cnt == 0, "R7 no strobe for zero", en_cnt, 0);
    chk(done_cnt == d0 + 1, "R7 done for zero", done_cnt, d0 + 1);
    chk(offset == -2, "R7 offset unchanged", offset, -2);

    // R6 upper boundary inclusive, then one beyond
    en_cnt = 0;
    send(22); settle();
    chk(offset == 20 && en_cnt == 22, "R6 target at +limit accepted", offset, 20);
    en_cnt = 0; r0 = rng_cnt;
    send(1); settle();
    chk(rng_cnt == r0 + 1, "R6 reject beyond +limit", rng_cnt, r0 + 1);
    chk(en_cnt == 0 && offset == 20, "R6 rejected request silent", en_cnt, 0);

    // R6 lower boundary
    r0 = rng_cnt;
    send(-41); settle();
    chk(rng_cnt == r0 + 1 && offset == 20, "R6 reject beyond -limit", offset, 20);
    send(-40); settle();
    chk(offset == -20, "R6 target at -limit accepted", offset, -20);

    // R8 request while busy is ignored
    en_cnt = 0;
    send(4);
    #1; req_valid = 1; req_steps = 10'(7);
    repeat (3) @(negedge clk);
    #1; req_valid = 0;
    settle();
    chk(en_cnt == 4 && offset == -16, "R8 busy request ignored", offset, -16);

    // R10 stray completion while idle
    stray = 1;
    repeat (4) @(negedge clk); #1;
    chk(offset == -16 && req_ready && !busy, "R10 stray ps_done ignored", offset, -16);

    // R9 timeout after first completed step
    en_cnt = 0; t0 = tmo_cnt;
    send(3);
    do begin @(negedge clk); #1; end while (en_cnt < 1);
    rsp_on = 0;
    settle();
    chk(tmo_cnt == t0 + 1, "R9 timeout pulse", tmo_cnt, t0 + 1);
    chk(offset == -15, "R9 offset keeps completed step", offset, -15);
    chk(en_cnt == 2, "R9 remaining steps dropped", en_cnt, 2);
    rsp_on = 1;

    // R11 reset mid request
    send(5);
    repeat (6) @(negedge clk);
    #1 rst_n = 0;
    #0.5;
    chk(!ps_en && !busy, "R11 outputs cleared by reset", {ps_en, busy}, 0);
    chk(offset == 0, "R11 offset cleared by reset", offset, 0);
    @(negedge clk); #1 rst_n = 1;
    repeat (3) @(negedge clk); #1;
    chk(req_ready && offset == 0 && !ps_en, "R11 idle after reset", offset, 0);

    // R3 after reset, a short request still sequences correctly
    en_cnt = 0;
    send(-2); settle();
    chk(en_cnt == 2 && offset == -2, "R3 sequence after reset", offset, -2);

    summary();
  end
endmodule